// File: doc/BRIEF.md
# Bitfield and bit-reorder unit

This block is a 64-bit datapath stage that moves, extracts and reorders bit fields. The field operations take a bit position `pos` and a field length `len`:

- **Merge insert** places a field into an existing destination word and keeps the other destination bits.
- **Extract-to-low** pulls a field down into the low bits of the destination and keeps the destination bits above it.
- **Extract**, signed or unsigned, returns the field right-aligned and extended.
- **Insert-in-zero**, signed or unsigned, places the field on a zero background and extends it above the field.

Beside the field operations, the unit performs these operations:

- a funnel extract from two registers;
- a full bit reversal;
- byte reversal over the whole operand, within each 16-bit halfword, or within each 32-bit word;
- sign or zero extension of the low byte, halfword or word;
- a leading-zero count;
- a leading-sign-bit count.

A size select picks 64-bit or 32-bit operation. In 32-bit mode only the low 32 bits of every operand take part, only `pos[4:0]` is used, and the upper 32 bits of the result are zero.

Operands, opcode and size are presented with `in_valid`. The result is registered and appears with `out_valid` one clock later. When no valid input is presented, the result register holds its value. The caller keeps the field legal: `1 <= len <= N` and `pos + len <= N`, where N is 32 or 64.

Top module: `bitfield_unit`

## Requirements
- R1: A result is registered: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only after a valid input and holds while `in_valid` is low. After reset, `out_valid` and `result` are 0.
- R2: Op 0 (merge insert) writes `src_a` bits len-1:0 into destination bits pos+len-1:pos and keeps all other bits of `dst_in`.
- R3: Op 1 (extract-to-low) writes `src_a` bits pos+len-1:pos into result bits len-1:0 and keeps `dst_in` bits N-1:len.
- R4: Op 2 (signed extract) and op 3 (unsigned extract) return `src_a` bits pos+len-1:pos, right-aligned and extended from field bit len-1: with its value for op 2, with zeros for op 3.
- R5: Op 4 (signed insert-in-zero) and op 5 (unsigned insert-in-zero) return `src_a` bits len-1:0 shifted left by `pos`. Bits below the field are zero. Bits above it are a copy of `src_a[len-1]` for op 4 and zero for op 5.
- R6: Op 6 (funnel extract) returns `src_a` bits pos-1:0 placed above `src_b` bits N-1:pos. With `pos`=0 the result is `src_b`.
- R7: Op 7 reverses the order of all N bits of `src_a`.
- R8: Op 8 reverses the N/8 bytes of `src_a`. Op 9 swaps the two bytes of every 16-bit halfword. Op 10 reverses the four bytes of every 32-bit word independently; in 32-bit mode op 10 equals op 8.
- R9: Ops 11, 12 and 13 sign-extend `src_a` bits 7:0, 15:0 and 31:0 to N bits. Ops 14, 15 and 16 zero-extend the same bits.
- R10: Op 17 returns the number of leading zero bits of the N-bit operand, from 0 to N; a zero operand gives N.
- R11: Op 18 returns how many bits directly below the MSB equal the MSB, from 0 to N-1.
- R12: When `wide` is 0 (32-bit mode), `result[63:32]` is zero for every op, and `src_a`, `src_b` and `dst_in` bits 63:32 have no effect.
- R13: Opcodes 19 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode valid this cycle |
| op | input | 5 | Operation code, 0 to 18 |
| wide | input | 1 | 1: 64-bit, 0: 32-bit |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source (funnel extract low part) |
| dst_in | input | 64 | Prior destination value for merge ops |
| pos | input | 6 | Field position / funnel shift |
| len | input | 7 | Field length, 1 to N |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Field operations are driven with random lengths and positions spread over the whole legal range, in both sizes. Directed fields at `pos`=0, at full width and touching the top bit separate off-by-one errors in the mask from errors in the shift. Sign-related ops get operands whose field top bit is set and also cleared, which tells a signed result from a zero-extended one. Upper-half noise in 32-bit mode exposes any leakage of bits 63:32. Counting ops get all-zero, all-one and single-bit operands, which fix both ends of each count range.

// File: rtl/bitfield_unit.sv
module bitfield_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [4:0]  op,
  input  logic        wide,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [63:0] dst_in,
  input  logic [5:0]  pos,
  input  logic [6:0]  len,
  output logic        out_valid,
  output logic [63:0] result
);

  localparam logic [4:0] OP_INS  = 5'd0,  OP_XIL  = 5'd1,  OP_SEXT = 5'd2,  OP_UEXT = 5'd3;
  localparam logic [4:0] OP_SIZ  = 5'd4,  OP_UIZ  = 5'd5,  OP_FUN  = 5'd6,  OP_RBIT = 5'd7;
  localparam logic [4:0] OP_REV  = 5'd8,  OP_RV16 = 5'd9,  OP_RV32 = 5'd10;
  localparam logic [4:0] OP_SXB  = 5'd11, OP_SXH  = 5'd12, OP_SXW  = 5'd13;
  localparam logic [4:0] OP_UXB  = 5'd14, OP_UXH  = 5'd15, OP_UXW  = 5'd16;
  localparam logic [4:0] OP_CLZ  = 5'd17, OP_CLS  = 5'd18;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  function automatic logic [6:0] lead0(input logic [63:0] v);
    lead0 = 7'd64;
    for (int i = 0; i < 64; i++)
      if (v[i]) lead0 = 7'(63 - i);
  endfunction

  logic [63:0] a_n, b_n, d_n, wmask, lm, fld, ext_f, rv, bs, h16, w32, cnt_x, cls_t, nxt;
  logic [5:0]  p, top;
  logic [6:0]  wbits;

  assign wmask = wide ? ONES : 64'h0000_0000_FFFF_FFFF;
  assign a_n   = src_a & wmask;
  assign b_n   = src_b & wmask;
  assign d_n   = dst_in & wmask;
  assign p     = wide ? pos : {1'b0, pos[4:0]};
  assign wbits = wide ? 7'd64 : 7'd32;
  assign lm    = ~(ONES << len);
  assign top   = len[5:0] - 6'd1;
  assign fld   = (a_n >> p) & lm;
  assign ext_f = fld | ((op == OP_SEXT && fld[top]) ? ~lm : 64'h0);
  assign cnt_x = wide ? src_a : {src_a[31:0], 32'hFFFF_FFFF};
  assign cls_t = (cnt_x ^ (cnt_x << 1)) | (wide ? 64'h1 : 64'h1_0000_0000);

  always_comb begin
    for (int i = 0; i < 64; i++) rv[i] = a_n[63 - i];
    for (int k = 0; k < 8; k++) begin
      bs[8*k +: 8]  = a_n[8*(7-k) +: 8];
      h16[8*k +: 8] = a_n[8*(k ^ 1) +: 8];
      w32[8*k +: 8] = a_n[8*(k ^ 3) +: 8];
    end
  end

  always_comb begin
    unique case (op)
      OP_INS:  nxt = (d_n & ~(lm << p)) | ((a_n << p) & (lm << p));
      OP_XIL:  nxt = (d_n & ~lm) | fld;
      OP_SEXT,
      OP_UEXT: nxt = ext_f;
      OP_SIZ:  nxt = ((a_n & lm) | (a_n[top] ? ~lm : 64'h0)) << p;
      OP_UIZ:  nxt = (a_n & lm) << p;
      OP_FUN:  nxt = (b_n >> p) | (a_n << (wbits - {1'b0, p}));
      OP_RBIT: nxt = wide ? rv : rv >> 32;
      OP_REV:  nxt = wide ? bs : bs >> 32;
      OP_RV16: nxt = h16;
      OP_RV32: nxt = w32;
      OP_SXB:  nxt = {{56{a_n[7]}}, a_n[7:0]};
      OP_SXH:  nxt = {{48{a_n[15]}}, a_n[15:0]};
      OP_SXW:  nxt = {{32{a_n[31]}}, a_n[31:0]};
      OP_UXB:  nxt = {56'h0, a_n[7:0]};
      OP_UXH:  nxt = {48'h0, a_n[15:0]};
      OP_UXW:  nxt = {32'h0, a_n[31:0]};
      OP_CLZ:  nxt = {57'h0, lead0(cnt_x)};
      OP_CLS:  nxt = {57'h0, lead0(cls_t)};
      default: nxt = 64'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'h0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt & wmask;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R1
  AST_INS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide && op == OP_INS) |=>
      ((result ^ $past(dst_in)) & ~($past(~(ONES << len)) << $past(pos))) == 64'h0); // R2
  AST_CLS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLS) |=> result < ($past(wide) ? 64'd64 : 64'd32)); // R11
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> result[63:32] == 32'h0); // R12
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > OP_CLS) |=> result == 64'h0); // R13

endmodule

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, wide = 1'b1;
  logic [4:0] op = '0;
  logic [63:0] src_a = '0, src_b = '0, dst_in = '0;
  logic [5:0] pos = '0;
  logic [6:0] len = '0;
  logic out_valid;
  logic [63:0] result;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  bitfield_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .src_a(src_a), .src_b(src_b), .dst_in(dst_in), .pos(pos), .len(len),
    .out_valid(out_valid), .result(result));

  function automatic logic [63:0] model(input logic [4:0] o, input logic w, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] d, input int p, input int n);
    int W, e, c;
    logic [63:0] r;
    logic done;
    W = w ? 64 : 32;
    r = '0;
    e = 0;
    c = 0;
    done = 1'b0;
    case (o)
      0: for (int i = 0; i < W; i++) r[i] = (i >= p && i < p + n) ? a[i - p] : d[i];
      1: for (int i = 0; i < W; i++) r[i] = (i < n) ? a[i + p] : d[i];
      2, 3: for (int i = 0; i < W; i++) r[i] = (i < n) ? a[p + i] : ((o == 2) ? a[p + n - 1] : 1'b0);
      4, 5: for (int i = 0; i < W; i++)
              r[i] = (i < p) ? 1'b0 : (i < p + n) ? a[i - p] : ((o == 4) ? a[n - 1] : 1'b0);
      6: for (int i = 0; i < W; i++) r[i] = (i < W - p) ? b[i + p] : a[i - (W - p)];
      7: for (int i = 0; i < W; i++) r[i] = a[W - 1 - i];
      8: for (int k = 0; k < W / 8; k++) for (int j = 0; j < 8; j++) r[8*k + j] = a[8*(W/8 - 1 - k) + j];
      9: for (int h = 0; h < W / 16; h++) for (int j = 0; j < 8; j++) begin
           r[16*h + j] = a[16*h + 8 + j];
           r[16*h + 8 + j] = a[16*h + j];
         end
      10: for (int g = 0; g < W / 32; g++) for (int k = 0; k < 4; k++) for (int j = 0; j < 8; j++)
            r[32*g + 8*k + j] = a[32*g + 8*(3 - k) + j];
      11, 12, 13, 14, 15, 16: begin
        e = (o == 11 || o == 14) ? 8 : (o == 12 || o == 15) ? 16 : 32;
        for (int i = 0; i < W; i++) r[i] = (i < e) ? a[i] : ((o <= 13) ? a[e - 1] : 1'b0);
      end
      17: begin
        for (int i = W - 1; i >= 0; i--) if (!done) begin if (a[i]) done = 1'b1; else c++; end
        r = 64'(c);
      end
      18: begin
        for (int i = W - 2; i >= 0; i--) if (!done) begin if (a[i] != a[W - 1]) done = 1'b1; else c++; end
        r = 64'(c);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string rtag(input logic [4:0] o);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8, 9, 10: return "R8";
      11, 12, 13, 14, 15, 16: return "R9";
      17: return "R10";
      18: return "R11";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [4:0] o, input logic w, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] d, input int p, input int n, input string tag);
    @(negedge clk);
    op = o; wide = w; src_a = a; src_b = b; dst_in = d; pos = 6'(p); len = 7'(n); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'h0, out_valid}, 64'h1);
    check(tag, result, model(o, w, a, b, d, p, n));
  endtask

  task automatic rnd_op(input logic [4:0] o);
    logic w;
    int W, n, p;
    logic [63:0] a;
    w = 1'($urandom);
    W = w ? 64 : 32;
    n = 1 + int'($urandom % W);
    p = (o == 6) ? int'($urandom % W) : int'($urandom % (W - n + 1));
    a = {$urandom, $urandom};
    if ($urandom % 4 == 0) a = {$urandom, $urandom} >> ($urandom % 64);
    exec(o, w, a, {$urandom, $urandom}, {$urandom, $urandom}, p, n, rtag(o));
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'h0, out_valid}, 64'h0);
    check("R1 reset result", result, 64'h0);
    rst_n = 1'b1;

    exec(5'd0, 1'b1, 64'h0123_4567_89AB_CDEF, '0, 64'hFFFF_0000_FFFF_0000, 0, 64, "R2 full width");
    exec(5'd0, 1'b1, 64'h5, '0, 64'hFFFF_FFFF_FFFF_FFFF, 61, 3, "R2 top field");
    exec(5'd1, 1'b1, 64'h8000_0000_0000_0000, '0, 64'h1234_5678_9ABC_DEF0, 63, 1, "R3 top bit");
    exec(5'd2, 1'b1, 64'h0000_0000_0000_0080, '0, '0, 7, 1, "R4 signed 1-bit");
    exec(5'd3, 1'b1, 64'h0000_0000_0000_0080, '0, '0, 4, 4, "R4 unsigned");
    exec(5'd4, 1'b1, 64'h0000_0000_0000_000A, '0, '0, 8, 4, "R5 signed iz");
    exec(5'd6, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1111_2222_3333_4444, '0, 0, 1, "R6 pos zero");
    exec(5'd6, 1'b0, 64'hDEAD_BEEF_0000_00FF, 64'hCAFE_0000_1234_5678, '0, 8, 1, "R6 narrow");
    exec(5'd10, 1'b0, 64'hFFFF_FFFF_1122_3344, '0, '0, 0, 1, "R8 word narrow");
    exec(5'd17, 1'b1, 64'h0, '0, '0, 0, 1, "R10 zero wide");
    exec(5'd17, 1'b0, 64'hFFFF_FFFF_0000_0000, '0, '0, 0, 1, "R10 zero narrow");
    exec(5'd17, 1'b1, 64'h8000_0000_0000_0000, '0, '0, 0, 1, "R10 msb set");
    exec(5'd18, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 0, 1, "R11 all ones");
    exec(5'd18, 1'b1, 64'h0, '0, '0, 0, 1, "R11 zero");
    exec(5'd18, 1'b0, 64'h0000_0000_FFFF_FFFF, '0, '0, 0, 1, "R11 narrow ones");
    exec(5'd18, 1'b1, 64'h4000_0000_0000_0000, '0, '0, 0, 1, "R11 no sign run");
    exec(5'd13, 1'b0, 64'h1234_5678_8000_0000, '0, '0, 0, 1, "R12 narrow sxw");
    exec(5'd0, 1'b0, 64'hFFFF_FFFF_0000_0003, '0, 64'hFFFF_FFFF_0000_0000, 30, 2, "R12 narrow ins");
    exec(5'd20, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 0, 1, "R13 op 20");
    exec(5'd31, 1'b0, 64'h1, '0, '0, 0, 1, "R13 op 31");

    exec(5'd7, 1'b1, 64'h0000_0000_0000_0001, '0, '0, 0, 1, "R7 lsb");
    @(negedge clk);
    src_a = 64'hFFFF; op = 5'd8;
    @(negedge clk);
    check("R1 hold valid", {63'h0, out_valid}, 64'h0);
    check("R1 hold result", result, 64'h8000_0000_0000_0000);

    for (int o = 0; o <= 18; o++)
      repeat (40) rnd_op(5'(o));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule